// File: doc/BRIEF.md
# Runtime-Configurable SINC Decimator for a One-Bit Microphone Stream

This block turns a one-bit pulse-density stream from a digital microphone into signed 24-bit PCM words. Every accepted bit is taken as +1 (a one) or −1 (a zero). The bits pass through a cascade of N running-sum stages. The cascade is read once per window of R accepted bits and then passes through N first-difference stages at the low rate. The result is scaled to full scale and clipped to 24 bits. The order N (1 to 5) and the window length R (8 to 256 in powers of two) come from two 4-bit fields that may change at any time.

Any change to either field flushes the filter. The block then discards the first N window results, because they are built from partial history. A ratio code of zero, or any code above the last valid one, turns the block into a pass-through that emits one full-scale word per bit. The channel number of the instance goes out with every word, so that several instances can share one sample sink downstream.

Top module: `sinc_decim`

## Requirements
- R1: During reset and after it, with no bits offered, `pcm_vld` stays low and `pcm_data` reads zero.
- R2: A window full of ones settles at 0x7FFFFF after clipping. A window full of zeros settles at exactly 0x800000.
- R3: Ratio code c in 1..6 gives R = 2^(c+2) and L = c+2. Each emitted word is the order-N boxcar response of the ±1 stream, sampled at the last bit of a window and multiplied by 2^(23−N·L). When N·L exceeds 23, the product is rounded toward minus infinity. The word is then clipped to the range −2^23 .. 2^23−1. Bits before the last flush count as zero.
- R4: Only bits with `pdm_vld` high count. Exactly one window result is produced per R accepted bits, and `pdm_bit` has no effect while `pdm_vld` is low.
- R5: After reset, or after a change of either configuration field, all filter state is cleared and the first N window results are withheld. A run of K full windows therefore yields K−N words.
- R6: Ratio code 0, and codes 7 to 15, select pass-through. Each accepted bit yields one word on the next cycle: 0x7FFFFF for a one and 0x800001 for a zero.
- R7: An order field of 0 acts as order 1. An order field of 6 to 15 acts as order 5.
- R8: `pcm_ch` always carries the instance's `CHAN_ID` parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pdm_bit | input | 1 | One-bit density sample |
| pdm_vld | input | 1 | Qualifies `pdm_bit` |
| cfg_order | input | 4 | Filter order field |
| cfg_ratio | input | 4 | Decimation ratio code |
| pcm_data | output | 24 | Signed output word |
| pcm_vld | output | 1 | One-cycle strobe for `pcm_data` |
| pcm_ch | output | CH_W | Channel number of this instance |

## Verification
Broken running-sum or difference state shows at the ports as a wrong word within one window of the fault. It persists until the next configuration change, because the running sums never forget. A counter slip moves every later word one bit of input or more, so the first compared word after the slip disagrees with the boxcar model. A wrong suppression count shows straight away as a word count of K−N plus or minus one. The full-scale and pass-through cases expose a clipping or sign-mapping error in the very first emitted word.

// File: rtl/sinc_pkg.sv
package sinc_pkg;

  // The window length is 2^(code + RATIO_L2_BASE) for valid codes.
  localparam int unsigned RATIO_L2_BASE = 2;

  // Maps the raw order field into the supported order range.
  function automatic int unsigned clamp_order(input int unsigned f, input int unsigned max_ord);
    if (f == 0) return 1;
    if (f > max_ord) return max_ord;
    return f;
  endfunction

  // Ratio code zero, or any code above the top valid one, means pass-through.
  function automatic bit ratio_off(input int unsigned code, input int unsigned max_code);
    return (code == 0) || (code > max_code);
  endfunction

  function automatic int unsigned ratio_log2(input int unsigned code);
    return code + RATIO_L2_BASE;
  endfunction

endpackage

// File: rtl/sinc_integ.sv
module sinc_integ #(
  parameter int STAGES = 5,
  parameter int W      = 42
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr,
  input  logic                           en,
  input  logic                           bit_in,
  input  logic [$clog2(STAGES+1)-1:0]    order,
  output logic [W-1:0]                   tap
);
  logic [W-1:0] acc [STAGES];
  logic [W-1:0] nxt [STAGES];
  logic [W-1:0] step;

  assign step = bit_in ? W'(1) : {W{1'b1}};

  // Chained sums: every stage sees the freshly updated value of the one before it.
  always_comb begin
    nxt[0] = acc[0] + step;
    for (int k = 1; k < STAGES; k++) nxt[k] = acc[k] + nxt[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) acc[k] <= '0;
    end else if (clr) begin
      for (int k = 0; k < STAGES; k++) acc[k] <= '0;
    end else if (en) begin
      for (int k = 0; k < STAGES; k++) acc[k] <= nxt[k];
    end
  end

  always_comb begin
    tap = acc[0];
    for (int k = 1; k < STAGES; k++)
      if (int'(order) == k + 1) tap = acc[k];
  end

  // R5: a flush leaves the selected running sum at zero.
  p_integ_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (tap == '0));

endmodule

// File: rtl/sinc_comb.sv
module sinc_comb #(
  parameter int STAGES = 5,
  parameter int W      = 42
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr,
  input  logic                           en,
  input  logic [$clog2(STAGES+1)-1:0]    order,
  input  logic [W-1:0]                   din,
  output logic [W-1:0]                   dout
);
  logic [W-1:0] dly [STAGES];
  logic [W-1:0] stg [STAGES+1];

  // Stages at or above the order pass their input straight through.
  always_comb begin
    stg[0] = din;
    for (int k = 0; k < STAGES; k++)
      stg[k+1] = (k < int'(order)) ? (stg[k] - dly[k]) : stg[k];
    dout = stg[STAGES];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) dly[k] <= '0;
    end else if (clr) begin
      for (int k = 0; k < STAGES; k++) dly[k] <= '0;
    end else if (en) begin
      for (int k = 0; k < STAGES; k++)
        if (k < int'(order)) dly[k] <= stg[k];
    end
  end

  // R5: a flush leaves the first and last delay registers at zero.
  p_comb_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (dly[0] == '0 && dly[STAGES-1] == '0));

  // R4: without a window tick the first delay register holds its value.
  p_comb_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(dly[0]));

endmodule

// File: rtl/sinc_decim.sv
module sinc_decim
  import sinc_pkg::*;
#(
  parameter int CHAN_ID   = 0,
  parameter int CH_W      = 2,
  parameter int MAX_ORD   = 5,
  parameter int MAX_CODE  = 6,
  parameter int OUT_W     = 24,
  parameter int CFG_W     = 4,
  parameter int RST_ORDER = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pdm_bit,
  input  logic             pdm_vld,
  input  logic [CFG_W-1:0] cfg_order,
  input  logic [CFG_W-1:0] cfg_ratio,
  output logic [OUT_W-1:0] pcm_data,
  output logic             pcm_vld,
  output logic [CH_W-1:0]  pcm_ch
);
  localparam int MAX_L = MAX_CODE + int'(RATIO_L2_BASE);
  localparam int ACC_W = MAX_ORD * MAX_L + 2;
  localparam int CNT_W = MAX_L;
  localparam int ORD_W = $clog2(MAX_ORD + 1);
  localparam logic [OUT_W-1:0] FS_POS = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] FS_NEG = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic [OUT_W-1:0] BY_NEG = {1'b1, {(OUT_W-2){1'b0}}, 1'b1};
  localparam logic signed [ACC_W-1:0] LIM_POS = ACC_W'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] LIM_NEG = -LIM_POS - ACC_W'(1);

  // Puts the full-precision value on the 24-bit grid and clips it.
  function automatic logic [OUT_W-1:0] fit(input logic signed [ACC_W-1:0] v, input int unsigned nl);
    logic signed [ACC_W-1:0] s;
    if (nl >= OUT_W - 1) s = v >>> (nl - (OUT_W - 1));
    else                 s = v <<< ((OUT_W - 1) - nl);
    if (s > LIM_POS) return FS_POS;
    if (s < LIM_NEG) return FS_NEG;
    return s[OUT_W-1:0];
  endfunction

  logic [CFG_W-1:0] ord_q, code_q;
  logic [CNT_W-1:0] cnt, win_mask;
  logic [ORD_W-1:0] ord_eff, skip_cnt;
  logic             byp, cfg_chg, in_take, filt_take, win_last, dec_tick;
  logic [ACC_W-1:0] integ_tap, comb_out;
  int unsigned      l2, nl;

  // Named internal events, brought out for the assertions below.
  assign cfg_chg   = (cfg_order != ord_q) || (cfg_ratio != code_q);
  assign in_take   = pdm_vld && !cfg_chg;
  assign byp       = ratio_off(int'(code_q), MAX_CODE);
  assign filt_take = in_take && !byp;
  assign ord_eff   = ORD_W'(clamp_order(int'(ord_q), MAX_ORD));
  assign l2        = byp ? 0 : ratio_log2(int'(code_q));
  assign nl        = int'(ord_eff) * l2;
  assign win_mask  = CNT_W'((32'd1 << l2) - 32'd1);
  assign win_last  = (cnt == win_mask);
  assign pcm_ch    = CH_W'(CHAN_ID);

  sinc_integ #(.STAGES(MAX_ORD), .W(ACC_W)) i_integ (
    .clk(clk), .rst_n(rst_n), .clr(cfg_chg), .en(filt_take),
    .bit_in(pdm_bit), .order(ord_eff), .tap(integ_tap));

  sinc_comb #(.STAGES(MAX_ORD), .W(ACC_W)) i_comb (
    .clk(clk), .rst_n(rst_n), .clr(cfg_chg), .en(dec_tick && !cfg_chg),
    .order(ord_eff), .din(integ_tap), .dout(comb_out));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ord_q    <= CFG_W'(RST_ORDER);
      code_q   <= '0;
      cnt      <= '0;
      dec_tick <= 1'b0;
      skip_cnt <= ORD_W'(RST_ORDER);
      pcm_vld  <= 1'b0;
      pcm_data <= '0;
    end else begin
      ord_q   <= cfg_order;
      code_q  <= cfg_ratio;
      pcm_vld <= 1'b0;
      if (cfg_chg) begin
        cnt      <= '0;
        dec_tick <= 1'b0;
        skip_cnt <= ORD_W'(clamp_order(int'(cfg_order), MAX_ORD));
      end else begin
        dec_tick <= filt_take && win_last;
        if (filt_take) cnt <= win_last ? '0 : cnt + CNT_W'(1);
        if (in_take && byp) begin
          pcm_vld  <= 1'b1;
          pcm_data <= pdm_bit ? FS_POS : BY_NEG;
        end
        if (dec_tick) begin
          if (skip_cnt != '0) skip_cnt <= skip_cnt - ORD_W'(1);
          else begin
            pcm_vld  <= 1'b1;
            pcm_data <= fit($signed(comb_out), nl);
          end
        end
      end
    end
  end

  // R4: a window tick only follows an accepted bit.
  p_tick_after_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_tick |-> $past(in_take));

  // R4: the bit counter never runs past the window length.
  p_count_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt <= win_mask) || cfg_chg);

  // R5: a withheld window produces no strobe.
  p_skip_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_tick && skip_cnt != '0 && !cfg_chg) |=> !pcm_vld);

  // R6: in pass-through every accepted bit is echoed on the next cycle.
  p_bypass_echo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_take && byp) |=> pcm_vld);

endmodule

// File: tb/test_sinc_decim.sv
`timescale 1ns/1ps
module test_sinc_decim;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pdm_bit = 1'b0;
  logic        pdm_vld = 1'b0;
  logic [3:0]  cfg_order = 4'd3;
  logic [3:0]  cfg_ratio = 4'd0;
  logic [23:0] pcm_data;
  logic        pcm_vld;
  logic [1:0]  pcm_ch;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;
  bit xs [0:4095];
  longint got [0:63];
  int ngot = 0;
  longint hh [0:2047];
  longint tmp [0:2047];
  int hlen;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  sinc_decim #(.CHAN_ID(2), .CH_W(2)) i_sinc_decim (
    .clk(clk), .rst_n(rst_n), .pdm_bit(pdm_bit), .pdm_vld(pdm_vld),
    .cfg_order(cfg_order), .cfg_ratio(cfg_ratio),
    .pcm_data(pcm_data), .pcm_vld(pcm_vld), .pcm_ch(pcm_ch));

  always @(negedge clk)
    if (pcm_vld && ngot < 64) begin
      got[ngot] = longint'($signed(pcm_data));
      ngot++;
    end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit rnd_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // Boxcar of length r convolved with itself n times.
  task automatic build_kernel(input int n, input int r);
    hlen = 1; hh[0] = 1;
    for (int s = 0; s < n; s++) begin
      for (int i = 0; i < hlen + r - 1; i++) tmp[i] = 0;
      for (int i = 0; i < hlen; i++)
        for (int k = 0; k < r; k++) tmp[i+k] += hh[i];
      hlen = hlen + r - 1;
      for (int i = 0; i < hlen; i++) hh[i] = tmp[i];
    end
  endtask

  function automatic longint model_word(input int j, input int r, input int nl);
    longint y = 0;
    longint q;
    longint d;
    int last = j * r + r - 1;
    for (int k = 0; k < hlen; k++) begin
      int idx = last - k;
      if (idx >= 0) y += hh[k] * (xs[idx] ? 64'sd1 : -64'sd1);
    end
    if (nl > 23) begin
      d = 64'sd1 << (nl - 23);
      q = y / d;
      if (y < 0 && q * d != y) q = q - 1;
    end else q = y * (64'sd1 << (23 - nl));
    if (q > 8388607) q = 8388607;
    if (q < -8388608) q = -8388608;
    return q;
  endfunction

  task automatic feed_bit(input bit b, input int gap);
    for (int g = 0; g < gap; g++) begin
      pdm_vld = 1'b0; pdm_bit = ~b;
      @(posedge clk); #1;
    end
    pdm_vld = 1'b1; pdm_bit = b;
    @(posedge clk); #1;
  endtask

  // pat: 0 zeros, 1 ones, 2 pseudo-random
  task automatic run_case(input string req, input int ord_in, input int code_in,
                          input int nbits, input int pat, input int gap, input int prefill);
    int n_eff, r, nl, nwin, nexp;
    bit byp;
    int pre_o = 2, pre_c = 1;
    if (ord_in == 2 && code_in == 1) begin pre_o = 1; pre_c = 2; end
    n_eff = (ord_in == 0) ? 1 : (ord_in > 5 ? 5 : ord_in);
    byp = (code_in == 0) || (code_in > 6);
    r = byp ? 1 : (1 << (code_in + 2));
    nl = n_eff * (code_in + 2);
    pdm_vld = 1'b0; cfg_order = 4'(pre_o); cfg_ratio = 4'(pre_c);
    repeat (3) @(posedge clk); #1;
    for (int i = 0; i < prefill; i++) feed_bit(rnd_bit(), 0);
    pdm_vld = 1'b0; cfg_order = 4'(ord_in); cfg_ratio = 4'(code_in);
    repeat (3) @(posedge clk); #1;
    ngot = 0;
    for (int i = 0; i < nbits; i++) begin
      xs[i] = (pat == 2) ? rnd_bit() : bit'(pat);
      feed_bit(xs[i], gap);
    end
    pdm_vld = 1'b0;
    repeat (6) @(posedge clk); #1;
    check("R8", "channel", longint'(pcm_ch), 2);
    if (byp) begin
      check(req, "pass-through count", ngot, nbits);
      for (int i = 0; i < nbits && i < ngot; i++)
        check(req, "pass-through word", got[i], xs[i] ? 8388607 : -8388607);
    end else begin
      build_kernel(n_eff, r);
      nwin = nbits / r;
      nexp = nwin - n_eff;
      check("R5", "word count", ngot, nexp);
      for (int j = 0; j < nexp && j < ngot; j++)
        check(req, "word", got[j], model_word(j + n_eff, r, nl));
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "vld in reset", pcm_vld, 0);
    check("R1", "data in reset", pcm_data, 0);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "vld after reset", pcm_vld, 0);
    check("R1", "data after reset", pcm_data, 0);
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    run_case("R2", 3, 1, 64, 1, 0, 0);
    run_case("R2", 3, 1, 64, 0, 0, 0);
    run_case("R3", 2, 2, 160, 2, 0, 20);
    run_case("R3", 5, 6, 2048, 2, 0, 0);
    run_case("R3", 4, 4, 512, 2, 0, 0);
    run_case("R4", 1, 1, 80, 2, 2, 0);
    run_case("R6", 3, 0, 16, 2, 0, 0);
    run_case("R6", 2, 9, 16, 2, 0, 0);
    run_case("R7", 0, 1, 48, 2, 0, 0);
    run_case("R7", 12, 1, 80, 2, 0, 0);
    run_case("R5", 3, 2, 128, 2, 1, 43);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule